// File: doc/BRIEF.md
# Fully-Associative Translation Buffer with Address-Space Tags

This block is a small content-addressed store of page translations. Each slot holds the following fields:

- a virtual page number tag and a physical page number;
- an address-space number and a global flag that makes the slot match in any address space;
- per-mode read and write enable masks;
- fault-on-read and fault-on-write flags;
- a valid flag.

A lookup presents a virtual page number and the current address-space number. In the same cycle it gets back a hit flag, the index of the matching slot and that slot's fields. Every slot compares against the lookup at once, and the lowest matching index is reported.

Commands arrive on a single opcode input. The block acts on at most one command per cycle. Commands take effect at the next clock edge, so a lookup in the same cycle still sees the old contents.

- Insert writes the slot under a replacement pointer and moves the pointer on.
- Three invalidation commands clear slots:
  - every slot;
  - every slot that is not global;
  - the slots that a given page and address space would hit.
- An advance command steps the pointer without writing anything.

A second read port always shows the slot under the pointer. Software that manages fills can inspect that slot before replacing it.

The control is a single pointer register with a decoded command. The command decoder has six named states of the opcode:

- `OP_NOP`: the command held when idle.
- `OP_INSERT`: writes the slot and then returns the pointer transition "advance".
- `OP_FLUSH_ALL`: returns the pointer transition "reset to 0".
- `OP_FLUSH_LOCAL`, `OP_FLUSH_PAGE` and `OP_ADVANCE`. `OP_ADVANCE` returns "advance". `OP_NOP`, `OP_FLUSH_LOCAL` and `OP_FLUSH_PAGE` return "hold".

Top module: `xlate_cam`

## Requirements
- R1: After reset every slot is invalid, the pointer `nx_ptr` is 0, `nx_valid` is 0 and every lookup misses.
- R2: A lookup hits only when some valid slot has a tag equal to `lk_vpn` and is either global or holds an address-space number equal to `lk_asn`. On a hit, `lk_idx`, `lk_ppn`, `lk_rmask`, `lk_wmask`, `lk_frd` and `lk_fwr` give that slot's contents. On a miss all of these read 0.
- R3: When several slots match a lookup, the lowest index is reported.
- R4: `cmd_op` = 1 (insert) writes the slot at the pointer from the `cmd_*` fields and marks it valid. Any valid slot already there is overwritten. The pointer then advances by one.
- R5: The pointer wraps from DEPTH-1 to 0 on insert or advance.
- R6: `cmd_op` = 2 (flush all) invalidates every slot and sets the pointer to 0.
- R7: `cmd_op` = 3 (flush local) invalidates every slot whose global flag is clear, leaves global slots valid and leaves the pointer unchanged.
- R8: `cmd_op` = 4 (flush page) invalidates each valid slot whose tag equals `cmd_vpn` and that is global or has address-space number `cmd_asn`. When nothing matches, nothing changes.
- R9: The index port (`nx_ptr`, `nx_valid`, `nx_vpn`, `nx_ppn`, `nx_asn`, `nx_global`) always shows the slot at the pointer. `cmd_op` = 5 (advance) moves the pointer by one and leaves every slot unchanged. Codes 0, 6 and 7 do nothing.
- R10: A lookup in the same cycle as an insert or flush returns the contents from before that command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_vpn | input | VPN_W | Lookup virtual page number |
| lk_asn | input | ASN_W | Lookup address-space number |
| lk_hit | output | 1 | Lookup matched a slot |
| lk_idx | output | IDX_W | Index of the lowest matching slot |
| lk_ppn | output | PPN_W | Physical page of the hit |
| lk_rmask | output | MODE_N | Read-enable mode mask of the hit |
| lk_wmask | output | MODE_N | Write-enable mode mask of the hit |
| lk_frd | output | 1 | Fault-on-read flag of the hit |
| lk_fwr | output | 1 | Fault-on-write flag of the hit |
| cmd_op | input | 3 | Command code |
| cmd_vpn | input | VPN_W | Page for insert and flush page |
| cmd_asn | input | ASN_W | Address space for insert and flush page |
| cmd_ppn | input | PPN_W | Physical page for insert |
| cmd_global | input | 1 | Global flag for insert |
| cmd_rmask | input | MODE_N | Read mask for insert |
| cmd_wmask | input | MODE_N | Write mask for insert |
| cmd_frd | input | 1 | Fault-on-read for insert |
| cmd_fwr | input | 1 | Fault-on-write for insert |
| nx_ptr | output | IDX_W | Replacement pointer |
| nx_valid | output | 1 | Valid flag of the slot at the pointer |
| nx_vpn | output | VPN_W | Tag of the slot at the pointer |
| nx_ppn | output | PPN_W | Physical page of the slot at the pointer |
| nx_asn | output | ASN_W | Address-space number of the slot at the pointer |
| nx_global | output | 1 | Global flag of the slot at the pointer |

## Verification
The assertions take for granted that `cmd_op` holds a defined value on every clock edge after reset. The pointer and flush properties also assume that reset has been applied once before any command is issued.

The stimulus changes inputs only at falling edges and holds them for a full cycle. It issues defined codes only and starts commands after reset is released. Duplicate tags are inserted on purpose, in different and equal address spaces, so that the lowest-index and flush-page properties see more than one candidate slot.

// File: rtl/xlb_pkg.sv
package xlb_pkg;
    typedef enum logic [2:0] {
        OP_NOP         = 3'd0,
        OP_INSERT      = 3'd1,
        OP_FLUSH_ALL   = 3'd2,
        OP_FLUSH_LOCAL = 3'd3,
        OP_FLUSH_PAGE  = 3'd4,
        OP_ADVANCE     = 3'd5
    } xlb_op_e;

    typedef enum logic [1:0] {
        PTR_HOLD  = 2'd0,
        PTR_STEP  = 2'd1,
        PTR_CLEAR = 2'd2
    } xlb_ptr_act_e;
endpackage

// File: rtl/xlb_ctrl.sv
module xlb_ctrl
    import xlb_pkg::*;
#(
    parameter int DEPTH = 48,
    parameter int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       op,
    output logic [IDX_W-1:0] ptr,
    output logic             do_insert,
    output logic             do_flush_all,
    output logic             do_flush_local,
    output logic             do_flush_page
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

    xlb_op_e      op_e;
    xlb_ptr_act_e act;

    assign op_e = xlb_op_e'(op);

    // Output process: decode the command into strobes and a pointer action.
    always_comb begin
        do_insert      = 1'b0;
        do_flush_all   = 1'b0;
        do_flush_local = 1'b0;
        do_flush_page  = 1'b0;
        act            = PTR_HOLD;
        unique case (op_e)
            OP_INSERT: begin
                do_insert = 1'b1;
                act       = PTR_STEP;
            end
            OP_FLUSH_ALL: begin
                do_flush_all = 1'b1;
                act          = PTR_CLEAR;
            end
            OP_FLUSH_LOCAL: do_flush_local = 1'b1;
            OP_FLUSH_PAGE:  do_flush_page  = 1'b1;
            OP_ADVANCE:     act            = PTR_STEP;
            default:        act            = PTR_HOLD;
        endcase
    end

    // State process: the replacement pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= '0;
        end else begin
            unique case (act)
                PTR_STEP:  ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
                PTR_CLEAR: ptr <= '0;
                default:   ptr <= ptr;
            endcase
        end
    end

    assert_ptr_in_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ptr <= LAST);

    assert_ptr_steps_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 3'd1 || op == 3'd5) |=>
            ptr == (($past(ptr) == LAST) ? '0 : $past(ptr) + 1'b1));

    assert_ptr_cleared_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 3'd2) |=> ptr == '0);

    assert_ptr_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 3'd3 || op == 3'd4) |=> $stable(ptr));
endmodule

// File: rtl/xlb_slot.sv
module xlb_slot #(
    parameter int VPN_W  = 20,
    parameter int PPN_W  = 20,
    parameter int ASN_W  = 8,
    parameter int MODE_N = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic              kill_all,
    input  logic              kill_local,
    input  logic              kill_page,
    input  logic [VPN_W-1:0]  c_vpn,
    input  logic [ASN_W-1:0]  c_asn,
    input  logic [PPN_W-1:0]  c_ppn,
    input  logic              c_global,
    input  logic [MODE_N-1:0] c_rmask,
    input  logic [MODE_N-1:0] c_wmask,
    input  logic              c_frd,
    input  logic              c_fwr,
    input  logic [VPN_W-1:0]  q_vpn,
    input  logic [ASN_W-1:0]  q_asn,
    output logic              q_match,
    output logic              s_valid,
    output logic [VPN_W-1:0]  s_vpn,
    output logic [PPN_W-1:0]  s_ppn,
    output logic [ASN_W-1:0]  s_asn,
    output logic              s_global,
    output logic [MODE_N-1:0] s_rmask,
    output logic [MODE_N-1:0] s_wmask,
    output logic              s_frd,
    output logic              s_fwr
);
    logic page_hit;
    logic drop;

    assign q_match  = s_valid && (s_vpn == q_vpn) && (s_global || s_asn == q_asn);
    assign page_hit = s_valid && (s_vpn == c_vpn) && (s_global || s_asn == c_asn);
    assign drop     = kill_all || (kill_local && !s_global) || (kill_page && page_hit);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_valid <= 1'b0;
        end else if (wr) begin
            s_valid <= 1'b1;
        end else if (drop) begin
            s_valid <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (wr) begin
            s_vpn    <= c_vpn;
            s_ppn    <= c_ppn;
            s_asn    <= c_asn;
            s_global <= c_global;
            s_rmask  <= c_rmask;
            s_wmask  <= c_wmask;
            s_frd    <= c_frd;
            s_fwr    <= c_fwr;
        end
    end

    assert_page_flush_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (kill_page && !wr && s_valid && s_vpn == c_vpn && (s_global || s_asn == c_asn))
            |=> !s_valid);
endmodule

// File: rtl/xlb_pick.sv
module xlb_pick #(
    parameter int DEPTH = 48,
    parameter int IDX_W = $clog2(DEPTH)
) (
    input  logic [DEPTH-1:0] match,
    output logic             hit,
    output logic [IDX_W-1:0] idx
);
    // Scan downward so the lowest set bit is the last one written.
    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (match[i]) begin
                hit = 1'b1;
                idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/xlate_cam.sv
module xlate_cam #(
    parameter int DEPTH  = 48,
    parameter int VPN_W  = 20,
    parameter int PPN_W  = 20,
    parameter int ASN_W  = 8,
    parameter int MODE_N = 4,
    parameter int IDX_W  = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [VPN_W-1:0]  lk_vpn,
    input  logic [ASN_W-1:0]  lk_asn,
    output logic              lk_hit,
    output logic [IDX_W-1:0]  lk_idx,
    output logic [PPN_W-1:0]  lk_ppn,
    output logic [MODE_N-1:0] lk_rmask,
    output logic [MODE_N-1:0] lk_wmask,
    output logic              lk_frd,
    output logic              lk_fwr,
    input  logic [2:0]        cmd_op,
    input  logic [VPN_W-1:0]  cmd_vpn,
    input  logic [ASN_W-1:0]  cmd_asn,
    input  logic [PPN_W-1:0]  cmd_ppn,
    input  logic              cmd_global,
    input  logic [MODE_N-1:0] cmd_rmask,
    input  logic [MODE_N-1:0] cmd_wmask,
    input  logic              cmd_frd,
    input  logic              cmd_fwr,
    output logic [IDX_W-1:0]  nx_ptr,
    output logic              nx_valid,
    output logic [VPN_W-1:0]  nx_vpn,
    output logic [PPN_W-1:0]  nx_ppn,
    output logic [ASN_W-1:0]  nx_asn,
    output logic              nx_global
);
    logic             do_insert;
    logic             do_flush_all;
    logic             do_flush_local;
    logic             do_flush_page;
    logic [IDX_W-1:0] ptr;
    logic [DEPTH-1:0] match_vec;
    logic [DEPTH-1:0] valid_vec;
    logic [DEPTH-1:0] global_vec;
    logic             any_hit;
    logic [IDX_W-1:0] hit_idx;

    logic [VPN_W-1:0]  s_vpn   [DEPTH];
    logic [PPN_W-1:0]  s_ppn   [DEPTH];
    logic [ASN_W-1:0]  s_asn   [DEPTH];
    logic [MODE_N-1:0] s_rmask [DEPTH];
    logic [MODE_N-1:0] s_wmask [DEPTH];
    logic [DEPTH-1:0]  frd_vec;
    logic [DEPTH-1:0]  fwr_vec;

    xlb_ctrl #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_ctrl (
        .clk            (clk),
        .rst_n          (rst_n),
        .op             (cmd_op),
        .ptr            (ptr),
        .do_insert      (do_insert),
        .do_flush_all   (do_flush_all),
        .do_flush_local (do_flush_local),
        .do_flush_page  (do_flush_page)
    );

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        xlb_slot #(
            .VPN_W(VPN_W), .PPN_W(PPN_W), .ASN_W(ASN_W), .MODE_N(MODE_N)
        ) u_slot (
            .clk        (clk),
            .rst_n      (rst_n),
            .wr         (do_insert && ptr == IDX_W'(g)),
            .kill_all   (do_flush_all),
            .kill_local (do_flush_local),
            .kill_page  (do_flush_page),
            .c_vpn      (cmd_vpn),
            .c_asn      (cmd_asn),
            .c_ppn      (cmd_ppn),
            .c_global   (cmd_global),
            .c_rmask    (cmd_rmask),
            .c_wmask    (cmd_wmask),
            .c_frd      (cmd_frd),
            .c_fwr      (cmd_fwr),
            .q_vpn      (lk_vpn),
            .q_asn      (lk_asn),
            .q_match    (match_vec[g]),
            .s_valid    (valid_vec[g]),
            .s_vpn      (s_vpn[g]),
            .s_ppn      (s_ppn[g]),
            .s_asn      (s_asn[g]),
            .s_global   (global_vec[g]),
            .s_rmask    (s_rmask[g]),
            .s_wmask    (s_wmask[g]),
            .s_frd      (frd_vec[g]),
            .s_fwr      (fwr_vec[g])
        );
    end

    xlb_pick #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_pick (
        .match (match_vec),
        .hit   (any_hit),
        .idx   (hit_idx)
    );

    always_comb begin
        lk_hit   = any_hit;
        lk_idx   = '0;
        lk_ppn   = '0;
        lk_rmask = '0;
        lk_wmask = '0;
        lk_frd   = 1'b0;
        lk_fwr   = 1'b0;
        if (any_hit) begin
            lk_idx   = hit_idx;
            lk_ppn   = s_ppn[hit_idx];
            lk_rmask = s_rmask[hit_idx];
            lk_wmask = s_wmask[hit_idx];
            lk_frd   = frd_vec[hit_idx];
            lk_fwr   = fwr_vec[hit_idx];
        end
    end

    assign nx_ptr    = ptr;
    assign nx_valid  = valid_vec[ptr];
    assign nx_vpn    = s_vpn[ptr];
    assign nx_ppn    = s_ppn[ptr];
    assign nx_asn    = s_asn[ptr];
    assign nx_global = global_vec[ptr];

    assert_hit_is_real_R2: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> (valid_vec[lk_idx] && s_vpn[lk_idx] == lk_vpn &&
                    (global_vec[lk_idx] || s_asn[lk_idx] == lk_asn)));

    assert_flush_all_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_op == 3'd2) |=> valid_vec == '0);

    assert_flush_local_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_op == 3'd3) |=> (valid_vec & ~global_vec) == '0);

    assert_insert_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_op == 3'd1) |=> valid_vec[$past(ptr)]);
endmodule

// File: tb/xlate_cam_tb.sv
module xlate_cam_tb;
    localparam int DEPTH = 48;
    localparam int VW = 20;
    localparam int PW = 20;
    localparam int AW = 8;
    localparam int MN = 4;
    localparam int IW = $clog2(DEPTH);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic [VW-1:0] lk_vpn = '0;
    logic [AW-1:0] lk_asn = '0;
    logic          lk_hit;
    logic [IW-1:0] lk_idx;
    logic [PW-1:0] lk_ppn;
    logic [MN-1:0] lk_rmask, lk_wmask;
    logic          lk_frd, lk_fwr;
    logic [2:0]    cmd_op = '0;
    logic [VW-1:0] cmd_vpn = '0;
    logic [AW-1:0] cmd_asn = '0;
    logic [PW-1:0] cmd_ppn = '0;
    logic          cmd_global = 1'b0;
    logic [MN-1:0] cmd_rmask = '0, cmd_wmask = '0;
    logic          cmd_frd = 1'b0, cmd_fwr = 1'b0;
    logic [IW-1:0] nx_ptr;
    logic          nx_valid;
    logic [VW-1:0] nx_vpn;
    logic [PW-1:0] nx_ppn;
    logic [AW-1:0] nx_asn;
    logic          nx_global;

    xlate_cam #(.DEPTH(DEPTH), .VPN_W(VW), .PPN_W(PW), .ASN_W(AW), .MODE_N(MN)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .lk_vpn(lk_vpn), .lk_asn(lk_asn), .lk_hit(lk_hit), .lk_idx(lk_idx),
        .lk_ppn(lk_ppn), .lk_rmask(lk_rmask), .lk_wmask(lk_wmask),
        .lk_frd(lk_frd), .lk_fwr(lk_fwr),
        .cmd_op(cmd_op), .cmd_vpn(cmd_vpn), .cmd_asn(cmd_asn), .cmd_ppn(cmd_ppn),
        .cmd_global(cmd_global), .cmd_rmask(cmd_rmask), .cmd_wmask(cmd_wmask),
        .cmd_frd(cmd_frd), .cmd_fwr(cmd_fwr),
        .nx_ptr(nx_ptr), .nx_valid(nx_valid), .nx_vpn(nx_vpn), .nx_ppn(nx_ppn),
        .nx_asn(nx_asn), .nx_global(nx_global)
    );

    // Reference model, written from the requirements.
    bit            m_val [DEPTH];
    logic [VW-1:0] m_vpn [DEPTH];
    logic [PW-1:0] m_ppn [DEPTH];
    logic [AW-1:0] m_asn [DEPTH];
    bit            m_glb [DEPTH];
    logic [MN-1:0] m_rm  [DEPTH];
    logic [MN-1:0] m_wm  [DEPTH];
    bit            m_fr  [DEPTH];
    bit            m_fw  [DEPTH];
    int            m_ptr = 0;

    typedef struct {
        bit            hit;
        int            idx;
        logic [PW-1:0] ppn;
        logic [MN-1:0] rm;
        logic [MN-1:0] wm;
        bit            fr;
        bit            fw;
        int            nptr;
        bit            nval;
        logic [VW-1:0] nvpn;
        logic [AW-1:0] nasn;
        bit            nglb;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];
    int    n_checks = 0;
    int    n_fail = 0;
    bit    done = 1'b0;

    // Staging values, applied at the next falling edge.
    logic [2:0]    s_op;
    logic [VW-1:0] s_cvpn, s_lvpn;
    logic [AW-1:0] s_casn, s_lasn;
    logic [PW-1:0] s_cppn;
    bit            s_cglb;

    function automatic int wrap(input int p);
        return (p == DEPTH - 1) ? 0 : p + 1;
    endfunction

    function automatic exp_t predict();
        exp_t e;
        e = '{default: '0};
        for (int i = 0; i < DEPTH; i++) begin
            if (!e.hit && m_val[i] && m_vpn[i] == s_lvpn && (m_glb[i] || m_asn[i] == s_lasn)) begin
                e.hit = 1; e.idx = i; e.ppn = m_ppn[i]; e.rm = m_rm[i];
                e.wm = m_wm[i]; e.fr = m_fr[i]; e.fw = m_fw[i];
            end
        end
        e.nptr = m_ptr;
        e.nval = m_val[m_ptr];
        e.nvpn = m_val[m_ptr] ? m_vpn[m_ptr] : '0;
        e.nasn = m_val[m_ptr] ? m_asn[m_ptr] : '0;
        e.nglb = m_val[m_ptr] ? m_glb[m_ptr] : 1'b0;
        return e;
    endfunction

    task automatic apply_model();
        case (s_op)
            3'd1: begin
                m_val[m_ptr] = 1; m_vpn[m_ptr] = s_cvpn; m_asn[m_ptr] = s_casn;
                m_ppn[m_ptr] = s_cppn; m_glb[m_ptr] = s_cglb;
                m_rm[m_ptr] = s_cvpn[3:0]; m_wm[m_ptr] = ~s_cvpn[3:0];
                m_fr[m_ptr] = s_cppn[0]; m_fw[m_ptr] = s_cppn[1];
                m_ptr = wrap(m_ptr);
            end
            3'd2: begin
                for (int i = 0; i < DEPTH; i++) m_val[i] = 0;
                m_ptr = 0;
            end
            3'd3: for (int i = 0; i < DEPTH; i++) if (!m_glb[i]) m_val[i] = 0;
            3'd4: for (int i = 0; i < DEPTH; i++)
                      if (m_val[i] && m_vpn[i] == s_cvpn && (m_glb[i] || m_asn[i] == s_casn))
                          m_val[i] = 0;
            3'd5: m_ptr = wrap(m_ptr);
            default: ;
        endcase
    endtask

    // Driver: one cycle of stimulus, pushing the expected result when asked.
    task automatic step(input bit chk, input string rq);
        @(negedge clk);
        cmd_op = s_op; cmd_vpn = s_cvpn; cmd_asn = s_casn; cmd_ppn = s_cppn;
        cmd_global = s_cglb; cmd_rmask = s_cvpn[3:0]; cmd_wmask = ~s_cvpn[3:0];
        cmd_frd = s_cppn[0]; cmd_fwr = s_cppn[1];
        lk_vpn = s_lvpn; lk_asn = s_lasn;
        if (chk) begin
            exp_q.push_back(predict());
            tag_q.push_back(rq);
        end
        apply_model();
        s_op = 3'd0;
    endtask

    task automatic ins(input logic [VW-1:0] v, input logic [AW-1:0] a,
                       input logic [PW-1:0] p, input bit g);
        s_op = 3'd1; s_cvpn = v; s_casn = a; s_cppn = p; s_cglb = g;
        step(0, "");
    endtask

    task automatic look(input logic [VW-1:0] v, input logic [AW-1:0] a, input string rq);
        s_op = 3'd0; s_lvpn = v; s_lasn = a;
        step(1, rq);
    endtask

    task automatic cmd(input logic [2:0] op, input logic [VW-1:0] v,
                       input logic [AW-1:0] a, input string rq);
        s_op = op; s_cvpn = v; s_casn = a;
        step(1, rq);
    endtask

    // Monitor: samples shortly before each rising edge and compares.
    initial begin
        forever begin
            @(negedge clk);
            #3;
            if (exp_q.size() > 0) begin
                exp_t  e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                n_checks++;
                if (lk_hit !== e.hit || int'(lk_idx) != e.idx || lk_ppn !== e.ppn ||
                    lk_rmask !== e.rm || lk_wmask !== e.wm || lk_frd !== e.fr ||
                    lk_fwr !== e.fw || int'(nx_ptr) != e.nptr || nx_valid !== e.nval ||
                    (e.nval && (nx_vpn !== e.nvpn || nx_asn !== e.nasn || nx_global !== e.nglb))) begin
                    n_fail++;
                    $display("FAIL %s: hit=%0d idx=%0d ppn=%h rm=%h wm=%h fr=%0d fw=%0d ptr=%0d nv=%0d nvpn=%h | exp hit=%0d idx=%0d ppn=%h rm=%h wm=%h fr=%0d fw=%0d ptr=%0d nv=%0d nvpn=%h",
                             t, lk_hit, lk_idx, lk_ppn, lk_rmask, lk_wmask, lk_frd, lk_fwr,
                             nx_ptr, nx_valid, nx_vpn, e.hit, e.idx, e.ppn, e.rm, e.wm,
                             e.fr, e.fw, e.nptr, e.nval, e.nvpn);
                end
            end
        end
    end

    initial begin
        #2000000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not complete");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        s_op = 0; s_cvpn = 0; s_casn = 0; s_cppn = 0; s_cglb = 0; s_lvpn = 0; s_lasn = 0;
        for (int i = 0; i < DEPTH; i++) begin
            m_val[i] = 0; m_glb[i] = 0; m_vpn[i] = 0; m_asn[i] = 0; m_ppn[i] = 0;
            m_rm[i] = 0; m_wm[i] = 0; m_fr[i] = 0; m_fw[i] = 0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        look(20'h00100, 8'd3, "R1 reset empty");
        look(20'h00000, 8'd0, "R1 reset zero page");

        // Insert with a lookup of the same page in the same cycle.
        s_lvpn = 20'h00100; s_lasn = 8'd3;
        s_op = 3'd1; s_cvpn = 20'h00100; s_casn = 8'd3; s_cppn = 20'h0AAA1; s_cglb = 0;
        step(1, "R10 lookup during insert sees old contents");
        look(20'h00100, 8'd3, "R2 R4 hit after insert");
        look(20'h00100, 8'd4, "R2 miss on other space");
        look(20'h00101, 8'd3, "R2 miss on other page");

        ins(20'h00200, 8'd5, 20'h0CCC2, 1);
        look(20'h00200, 8'd9, "R2 global matches any space");

        ins(20'h00100, 8'd3, 20'h0BBB3, 0);
        look(20'h00100, 8'd3, "R3 lowest index of duplicates");
        ins(20'h00100, 8'd7, 20'h0DDD0, 0);
        look(20'h00100, 8'd7, "R2 same page other space");

        cmd(3'd4, 20'h00555, 8'd1, "R8 page flush with no match");
        look(20'h00100, 8'd3, "R8 no-match flush left slots");
        cmd(3'd4, 20'h00100, 8'd3, "R10 lookup during page flush");
        look(20'h00100, 8'd3, "R8 both matching slots removed");
        look(20'h00100, 8'd7, "R8 other space slot kept");
        look(20'h00200, 8'd1, "R8 global slot kept");

        cmd(3'd3, 20'h0, 8'd0, "R7 flush local issued");
        look(20'h00100, 8'd7, "R7 local slot removed");
        look(20'h00200, 8'd2, "R7 global slot kept");

        cmd(3'd5, 20'h0, 8'd0, "R9 advance issued");
        look(20'h00200, 8'd2, "R9 advance leaves contents");
        cmd(3'd6, 20'h0, 8'd0, "R9 unused code 6");
        cmd(3'd7, 20'h0, 8'd0, "R9 unused code 7");
        look(20'h00200, 8'd2, "R9 unused codes change nothing");

        // Fill until the pointer wraps back to slot 0 and overwrites it.
        for (int k = 0; k < DEPTH - 5; k++) begin
            ins(20'h01000 + VW'(k), 8'd1, 20'h10000 + PW'(k), 0);
        end
        look(20'h01000, 8'd1, "R5 pointer at slot 0 after wrap");
        ins(20'h0F0F0, 8'd2, 20'h0EEE2, 0);
        look(20'h00100, 8'd3, "R4 overwritten slot 0 gone");
        look(20'h0F0F0, 8'd2, "R4 new slot 0 present");
        look(20'h01010, 8'd1, "R4 fill slot intact");

        cmd(3'd2, 20'h0, 8'd0, "R10 lookup during flush all");
        look(20'h0F0F0, 8'd2, "R6 flush all empties");
        look(20'h00200, 8'd2, "R6 global also cleared");

        for (int k = 0; k < DEPTH - 1; k++) begin
            s_op = 3'd5; step(0, "");
        end
        look(20'h0, 8'd0, "R5 pointer at last slot");
        cmd(3'd5, 20'h0, 8'd0, "R5 advance from last");
        look(20'h0, 8'd0, "R5 advance wraps to 0");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule